// File: doc/BRIEF.md
# DDR Read Capture Datapath

This block brings read data from a DDR SDRAM data bus into the memory controller's clock domain. Each DQ bit is sampled twice per strobe period: the rising edge of DQS latches one word and the rising edge of the complementary strobe DQSn latches the next. The two words form a pair. At every edge of the resynchronization clock that pair is moved into the resync domain, together with a read-valid qualifier that the command side has already aligned to that clock.

In half-rate builds, two consecutive qualified pairs are joined into one 4n-bit word. This is done with a phase toggle that runs at half the resync rate. In full-rate builds, each qualified pair is written on its own and the two upper n-bit lanes are held at zero. Completed words go into a small dual-port RAM, which is written in the resync domain and read in the controller domain. The write and read pointers cross between the domains in Gray code through two-flop synchronizers. A mapping stage after the RAM read port reorders the lanes into the controller's read-data layout. The controller sees a one-cycle valid flag for each word.

Top module: `ddr_read_capture`

## Requirements
- R1: The DQ value present at a DQS rising edge is the rising word of a pair, and the DQ value present at a DQSn rising edge is the falling word of that same pair. One pair is taken into the resync domain at each resync clock edge.
- R2: A pair is kept only if rdValidIn is high at the resync edge that takes that pair in. Strobe edges during unqualified cycles produce no output word.
- R3: In half-rate mode (HALF_RATE=1), qualified pairs are grouped two by two in arrival order, whether or not idle cycles separate them. The first pair of a group supplies r0 and f0, and the second supplies r1 and f1.
- R4: In half-rate mode the controller word is laid out as follows: bits [n-1:0] = r0, [2n-1:n] = r1, [3n-1:2n] = f0, [4n-1:3n] = f1.
- R5: In full-rate mode (HALF_RATE=0), every qualified pair gives one controller word with bits [n-1:0] = rising word, [2n-1:n] = falling word, and the upper 2n bits = 0.
- R6: Words reach the controller in the order they were completed, each exactly once, with ctlRdValid high for one controller cycle per word.
- R7: The write pointer, as seen in the controller domain, changes by at most one bit per controller cycle. This holds when the controller clock is not slower than the resync clock.
- R8: While reset is held, ctlRdValid is 0 and ctlRdata is 0. Pairs that are pending or still buffered when reset occurs are discarded, and the half-rate grouping restarts with the first pair after reset.
- R9: The buffer holds 2^AW words. The writer never completes a word while the buffer is full. With the controller clock at least as fast as the resync clock, every completed word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dq | input | DQ_W | Memory data bus |
| dqs | input | 1 | Read data strobe |
| dqsN | input | 1 | Complementary read data strobe |
| rdValidIn | input | 1 | Read-valid qualifier, resync-aligned |
| resyncClk | input | 1 | Resynchronization clock |
| resyncRstN | input | 1 | Active-low reset for strobe and resync domains |
| ctlClk | input | 1 | Controller clock |
| ctlRstN | input | 1 | Active-low reset for controller domain |
| ctlRdata | output | 4*DQ_W | Mapped read data word |
| ctlRdValid | output | 1 | One-cycle valid per delivered word |

## Verification
The assertions rely on four conditions. The strobe edges fall well inside each resync period, so the capture registers are stable when the resync edge samples them. The controller clock runs at least as fast as the resync clock, so Gray steps arrive one at a time and the buffer drains faster than it fills. Both resets are applied together. rdValidIn changes only just after a resync edge. The stimulus meets all of these by driving every strobe edge and data change at fixed offsets after each resync edge, by running the controller clock at 8 ns against a 10 ns resync clock, and by releasing both resets together.

// File: rtl/ddr_rc_pkg.sv
`timescale 1ns/1ps
package ddr_rc_pkg;
  // Strobes issued by the control section to the datapath
  typedef struct packed {
    logic wrEn;       // write the assembled word into the buffer
    logic upperHalf;  // half-rate: the next qualified pair completes a word
    logic rdEn;       // read one word out in the controller domain
  } rcStrobes_t;
endpackage

// File: rtl/ddr_rc_ctrl.sv
`timescale 1ns/1ps
module ddr_rc_ctrl
  import ddr_rc_pkg::*;
#(
  parameter int HALF_RATE = 1,
  parameter int AW        = 3
) (
  input  logic          resyncClk,
  input  logic          resyncRstN,
  input  logic          ctlClk,
  input  logic          ctlRstN,
  input  logic          pairValid,
  output rcStrobes_t    strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] rdGraySync1, rdGraySync2, wrGraySync1, wrGraySync2;
  logic phaseQ, wordDone, full, empty, wrEn, rdEn;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Rate-dependent word completion
  generate
    if (HALF_RATE != 0) begin : g_half
      always_ff @(posedge resyncClk or negedge resyncRstN) begin
        if (!resyncRstN)    phaseQ <= 1'b0;
        else if (pairValid) phaseQ <= ~phaseQ;
      end
      assign wordDone = pairValid & phaseQ;
    end else begin : g_full
      assign phaseQ   = 1'b0;
      assign wordDone = pairValid;
    end
  endgenerate

  // Write side (resync domain)
  assign full = (wrGray == {~rdGraySync2[PW-1:PW-2], rdGraySync2[PW-3:0]});
  assign wrEn = wordDone & ~full;

  always_ff @(posedge resyncClk or negedge resyncRstN) begin
    if (!resyncRstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
    end else begin
      wrBin       <= wrBin + PW'(wrEn);
      wrGray      <= toGray(wrBin + PW'(wrEn));
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
    end
  end

  // Read side (controller domain)
  assign empty = (rdGray == wrGraySync2);
  assign rdEn  = ~empty;

  always_ff @(posedge ctlClk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
    end else begin
      rdBin       <= rdBin + PW'(rdEn);
      rdGray      <= toGray(rdBin + PW'(rdEn));
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
    end
  end

  assign strobes.wrEn      = wrEn;
  assign strobes.upperHalf = phaseQ;
  assign strobes.rdEn      = rdEn;
  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];

  // R9: the source never completes a word into a full buffer
  assert_no_overflow_R9: assert property (@(posedge resyncClk) disable iff (!resyncRstN)
    wordDone |-> !full);

  // R7: the synchronized write pointer moves one Gray step at a time
  assert_gray_step_R7: assert property (@(posedge ctlClk) disable iff (!ctlRstN)
    $countones(wrGraySync2 ^ $past(wrGraySync2)) <= 1);
endmodule

// File: rtl/ddr_rc_datapath.sv
`timescale 1ns/1ps
module ddr_rc_datapath
  import ddr_rc_pkg::*;
#(
  parameter int DQ_W      = 8,
  parameter int HALF_RATE = 1,
  parameter int AW        = 3
) (
  input  logic [DQ_W-1:0]   dq,
  input  logic              dqs,
  input  logic              dqsN,
  input  logic              rdValidIn,
  input  logic              resyncClk,
  input  logic              resyncRstN,
  input  logic              ctlClk,
  input  logic              ctlRstN,
  input  rcStrobes_t        strobes,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  output logic              pairValid,
  output logic [4*DQ_W-1:0] ctlRdata,
  output logic              ctlRdValid
);
  localparam int PAIR_W = 2 * DQ_W;
  localparam int WORD_W = 4 * DQ_W;
  localparam int DEPTH  = 1 << AW;

  logic [DQ_W-1:0]   riseQ, fallQ;
  logic [PAIR_W-1:0] syncPair;
  logic              syncValid;
  logic [WORD_W-1:0] wideWord;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] ramQ;
  logic              validQ;

  // Stage 1: strobe-edge capture
  always_ff @(posedge dqs or negedge resyncRstN) begin
    if (!resyncRstN) riseQ <= '0;
    else             riseQ <= dq;
  end

  always_ff @(posedge dqsN or negedge resyncRstN) begin
    if (!resyncRstN) fallQ <= '0;
    else             fallQ <= dq;
  end

  // Stage 2: resynchronization
  always_ff @(posedge resyncClk or negedge resyncRstN) begin
    if (!resyncRstN) begin
      syncPair  <= '0;
      syncValid <= 1'b0;
    end else begin
      syncPair  <= {fallQ, riseQ};
      syncValid <= rdValidIn;
    end
  end
  assign pairValid = syncValid;

  // Stage 3: rate demultiplexing and output mapping
  generate
    if (HALF_RATE != 0) begin : g_half
      logic [PAIR_W-1:0] lowHold;
      always_ff @(posedge resyncClk or negedge resyncRstN) begin
        if (!resyncRstN)                             lowHold <= '0;
        else if (syncValid && !strobes.upperHalf)    lowHold <= syncPair;
      end
      assign wideWord = {syncPair, lowHold};
      // buffer lanes {f1,r1,f0,r0} -> controller {f1,f0,r1,r0}
      assign ctlRdata = {ramQ[4*DQ_W-1:3*DQ_W], ramQ[2*DQ_W-1:DQ_W],
                         ramQ[3*DQ_W-1:2*DQ_W], ramQ[DQ_W-1:0]};

      // R3: a word is only written when the second pair of a group arrives
      assert_pair_group_R3: assert property (@(posedge resyncClk) disable iff (!resyncRstN)
        strobes.wrEn |-> strobes.upperHalf);
    end else begin : g_full
      assign wideWord = {{PAIR_W{1'b0}}, syncPair};
      assign ctlRdata = ramQ;

      // R5: upper lanes stay zero in full-rate operation
      assert_upper_zero_R5: assert property (@(posedge ctlClk) disable iff (!ctlRstN)
        ctlRdValid |-> (ctlRdata[WORD_W-1:PAIR_W] == '0));
    end
  endgenerate

  // Dual-port buffer: resync write, controller read
  always_ff @(posedge resyncClk) begin
    if (strobes.wrEn) mem[wrAddr] <= wideWord;
  end

  always_ff @(posedge ctlClk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      ramQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.rdEn;
      if (strobes.rdEn) ramQ <= mem[rdAddr];
    end
  end
  assign ctlRdValid = validQ;

  // R2: the control only writes on a qualified pair
  assert_write_qualified_R2: assert property (@(posedge resyncClk) disable iff (!resyncRstN)
    strobes.wrEn |-> syncValid);
endmodule

// File: rtl/ddr_read_capture.sv
`timescale 1ns/1ps
module ddr_read_capture
  import ddr_rc_pkg::*;
#(
  parameter int DQ_W      = 8,
  parameter int HALF_RATE = 1,
  parameter int AW        = 3
) (
  input  logic [DQ_W-1:0]   dq,
  input  logic              dqs,
  input  logic              dqsN,
  input  logic              rdValidIn,
  input  logic              resyncClk,
  input  logic              resyncRstN,
  input  logic              ctlClk,
  input  logic              ctlRstN,
  output logic [4*DQ_W-1:0] ctlRdata,
  output logic              ctlRdValid
);
  rcStrobes_t      strobes;
  logic [AW-1:0]   wrAddr, rdAddr;
  logic            pairValid;

  ddr_rc_ctrl #(.HALF_RATE(HALF_RATE), .AW(AW)) u_ctrl (
    .resyncClk (resyncClk),
    .resyncRstN(resyncRstN),
    .ctlClk    (ctlClk),
    .ctlRstN   (ctlRstN),
    .pairValid (pairValid),
    .strobes   (strobes),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr)
  );

  ddr_rc_datapath #(.DQ_W(DQ_W), .HALF_RATE(HALF_RATE), .AW(AW)) u_datapath (
    .dq        (dq),
    .dqs       (dqs),
    .dqsN      (dqsN),
    .rdValidIn (rdValidIn),
    .resyncClk (resyncClk),
    .resyncRstN(resyncRstN),
    .ctlClk    (ctlClk),
    .ctlRstN   (ctlRstN),
    .strobes   (strobes),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .pairValid (pairValid),
    .ctlRdata  (ctlRdata),
    .ctlRdValid(ctlRdValid)
  );
endmodule

// File: tb/ddr_read_capture_bench.sv
`timescale 1ns/1ps
module ddr_read_capture_bench;
  logic [7:0]  dq = '0;
  logic        dqs = 1'b0, dqsN = 1'b1, rdValidIn = 1'b0;
  logic        resyncClk = 1'b0, ctlClk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dataHalf, dataFull;
  logic        validHalf, validFull;

  int checks = 0, failures = 0, seenHalf = 0, seenFull = 0;
  bit done = 0;
  logic [31:0] expHalf[$], expFull[$];
  bit halfPending = 0;
  logic [7:0] holdR, holdF;

  always #5 resyncClk = ~resyncClk;   // 100 MHz
  always #4 ctlClk    = ~ctlClk;

  ddr_read_capture #(.DQ_W(8), .HALF_RATE(1), .AW(3)) u_ddr_read_capture (
    .dq(dq), .dqs(dqs), .dqsN(dqsN), .rdValidIn(rdValidIn),
    .resyncClk(resyncClk), .resyncRstN(rstN), .ctlClk(ctlClk), .ctlRstN(rstN),
    .ctlRdata(dataHalf), .ctlRdValid(validHalf));

  ddr_read_capture #(.DQ_W(8), .HALF_RATE(0), .AW(3)) u_ddr_read_capture_full (
    .dq(dq), .dqs(dqs), .dqsN(dqsN), .rdValidIn(rdValidIn),
    .resyncClk(resyncClk), .resyncRstN(rstN), .ctlClk(ctlClk), .ctlRstN(rstN),
    .ctlRdata(dataFull), .ctlRdValid(validFull));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mapHalf(input logic [7:0] r0, f0, r1, f1);
    return {f1, f0, r1, r0};
  endfunction

  function automatic logic [31:0] mapFull(input logic [7:0] r, f);
    return {16'h0000, f, r};
  endfunction

  // One strobe period per resync cycle; valid is sampled at the following edge
  task automatic beat(input bit v, input logic [7:0] r, input logic [7:0] f);
    @(posedge resyncClk);
    #1 dq = r; rdValidIn = v;
    #2 dqs = 1'b1; dqsN = 1'b0;
    #2 dq = f;
    #3 dqs = 1'b0; dqsN = 1'b1;
    if (v) begin
      expFull.push_back(mapFull(r, f));
      if (!halfPending) begin
        holdR = r; holdF = f; halfPending = 1;
      end else begin
        expHalf.push_back(mapHalf(holdR, holdF, r, f));
        halfPending = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, 8'($urandom), 8'($urandom));
  endtask

  // Output monitors (R6/R7: order, no duplication, single-cycle valid)
  always @(negedge ctlClk) begin
    if (rstN && validHalf) begin
      seenHalf++;
      if (expHalf.size() == 0) check("R6 half unexpected word", dataHalf, 32'hxxxxxxxx);
      else check("R4 half word layout R6/R7 order", dataHalf, expHalf.pop_front());
    end
    if (rstN && validFull) begin
      seenFull++;
      if (expFull.size() == 0) check("R6 full unexpected word", dataFull, 32'hxxxxxxxx);
      else check("R5 full word layout R6/R7 order", dataFull, expFull.pop_front());
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    rdValidIn = 1'b0;
    repeat (4) @(posedge resyncClk);
    @(negedge ctlClk);
    check("R8 reset valid half", {31'd0, validHalf}, 32'd0);
    check("R8 reset data half", dataHalf, 32'd0);
    check("R8 reset valid full", {31'd0, validFull}, 32'd0);
    check("R8 reset data full", dataFull, 32'd0);
    expHalf.delete(); expFull.delete(); halfPending = 0;
    @(posedge resyncClk); #2 rstN = 1'b1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    doReset();

    // R2: strobes toggle with data but no qualifier
    idle(6);
    repeat (20) @(posedge resyncClk);
    check("R2 unqualified strobes half", seenHalf, 0);
    check("R2 unqualified strobes full", seenFull, 0);

    // R1/R3/R4: directed burst of four pairs
    beat(1, 8'h11, 8'h22); beat(1, 8'h33, 8'h44);
    beat(1, 8'h55, 8'h66); beat(1, 8'h77, 8'h88);
    idle(3);

    // R3: grouping across an idle gap
    beat(1, 8'hA1, 8'hB1); idle(3); beat(1, 8'hA2, 8'hB2);
    idle(15);
    check("R1 directed half count", seenHalf, 3);
    check("R1 directed full count", seenFull, 6);

    // Random traffic
    for (int i = 0; i < 400; i++) beat(($urandom % 3) != 0, 8'($urandom), 8'($urandom));
    idle(20);

    // R8: half group left open, then reset discards it
    if (halfPending) beat(1, 8'hC0, 8'hC1);
    idle(10);
    beat(1, 8'hD0, 8'hD1);
    idle(15);
    check("R8 open group withheld half", expHalf.size(), 0);
    doReset();
    beat(1, 8'hE0, 8'hE1); beat(1, 8'hE2, 8'hE3);
    check("R8 regroup after reset", expHalf[0], mapHalf(8'hE0, 8'hE1, 8'hE2, 8'hE3));

    // R9: full-rate back-to-back stream drains without loss
    for (int i = 0; i < 40; i++) beat(1, 8'(i), 8'(8'hFF - i));
    idle(30);
    check("R9 all half words delivered", expHalf.size(), 0);
    check("R9 all full words delivered", expFull.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule